// File: doc/BRIEF.md
# Per-Core Interrupt Acceptor with End-of-Interrupt Retirement

This block sits next to one processor core and takes in interrupt messages, each of which names an 8-bit vector. Every accepted message sets one bit of a 256-bit request bitmap. The block offers the numerically highest requested vector to the core over a valid/acknowledge pair. It only offers a vector that outranks everything the core is already servicing. When the core acknowledges, the offered vector moves from the request bitmap to an in-service bitmap.

Software reaches the block through a 32-bit register window with single-cycle reads and writes. A control word holds a master enable and the spurious vector. Any write to the end-of-interrupt word retires the highest vector in service; the write carries no vector number. Both bitmaps can be read back as 32-bit words.

Sometimes the core acknowledges while the offer it saw is no longer backed by a live request, for example just after software cleared the enable. In that case the block hands over the spurious vector. A spurious hand-over leaves both bitmaps untouched, so no later end-of-interrupt write is consumed by it.

Top module: `irq_acceptor`

## Requirements
- R1: After reset, the control word reads 0x000000FF (disabled, spurious vector 0xFF), `irq_valid` is low, and every bitmap word reads zero.
- R2: The control word is at byte offset 0xF0. Write data bit 8 is the enable and bits 7:0 are the spurious vector. Read data returns those nine bits and zero in bits 31:9.
- R3: While the enable is clear, incoming messages are discarded and `irq_valid` does not rise.
- R4: An accepted message for vector v sets request bit v. That bit reads back as bit v%32 of the word at 0x60+4*(v/32). A message for a vector that is already requested merges into the same bit, so a single acknowledge clears it.
- R5: `irq_valid` is high in the second cycle after the message edge, with `irq_vector` equal to the numerically highest requested vector.
- R6: Acknowledging while `irq_valid` is high and a real request stands has three effects. `irq_vector` in that cycle names the vector. The vector's request bit clears. Its in-service bit sets, and that bit reads back as bit v%32 of the word at 0x40+4*(v/32).
- R7: A requested vector is offered only when it is strictly higher than the highest in-service vector. An equal or lower request keeps `irq_valid` low.
- R8: Any write to byte offset 0xB0, whatever its data, clears the highest set in-service bit. With no bit in service, such a write changes nothing.
- R9: An acknowledge taken while `irq_valid` is high but no offerable request remains delivers the spurious vector on `irq_vector` and leaves both bitmaps unchanged.
- R10: Reads of unimplemented offsets, and of the end-of-interrupt word, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_vector | input | 8 | Vector carried by the message |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, zero otherwise |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_vector | output | 8 | Offered vector, or the spurious vector when no request backs the offer |
| irq_ack | input | 1 | Core takes the offered vector |

## Verification
The bench builds the block with its default of 256 vectors, which gives eight 32-bit words per bitmap. Vectors 0x00 and 0xFF, the two ends of the priority order, are both reachable, as are vectors in different words of the read window. The spurious path is reached by clearing the enable while an offer is standing. The equal-priority hold case is reached by re-requesting a vector that is still in service.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

  // Index of the highest set bit in a 32-bit word (0 when the word is empty).
  function automatic logic [4:0] top_bit32(input logic [31:0] w);
    logic [4:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (w[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/irqa_bitmap.sv
module irqa_bitmap #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits
);

  logic [N-1:0] set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    set_mask[set_idx] = set_en;
    clr_mask[clr_idx] = clr_en;
  end

  // A set in the same cycle as a clear of the same bit wins: the set is newer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else        bits <= (bits & ~clr_mask) | set_mask;
  end

endmodule

// File: rtl/irqa_prio.sv
module irqa_prio
  import irqa_pkg::*;
#(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] top
);

  localparam int NW = N / 32;
  localparam int GW = $clog2(NW);

  logic [NW-1:0] grp_any;
  logic [4:0]    grp_idx [NW];
  logic [GW-1:0] g_sel;

  for (genvar g = 0; g < NW; g++) begin : g_word
    assign grp_any[g] = |bits[g*32 +: 32];
    assign grp_idx[g] = top_bit32(bits[g*32 +: 32]);
  end

  always_comb begin
    g_sel = '0;
    any   = 1'b0;
    for (int g = 0; g < NW; g++) begin
      if (grp_any[g]) begin
        g_sel = GW'(g);
        any   = 1'b1;
      end
    end
  end

  assign top = {g_sel, grp_idx[g_sel]};

  AST_PICK_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> bits[top]); // R5

endmodule

// File: rtl/irqa_regs.sv
module irqa_regs #(
  parameter int             N        = 256,
  parameter int             VW       = $clog2(N),
  parameter int             AW       = 8,
  parameter int             EN_BIT   = 8,
  parameter logic [AW-1:0]  CTRL_OFS = 8'hF0,
  parameter logic [AW-1:0]  EOI_OFS  = 8'hB0,
  parameter logic [AW-1:0]  ISR_OFS  = 8'h40,
  parameter logic [AW-1:0]  IRR_OFS  = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  output logic          en,
  output logic [VW-1:0] spur,
  output logic          eoi_wr
);

  localparam int            NW     = N / 32;
  localparam int            WW     = AW - 2;
  localparam logic [WW-1:0] CTRL_W = CTRL_OFS[AW-1:2];
  localparam logic [WW-1:0] EOI_W  = EOI_OFS[AW-1:2];
  localparam logic [WW-1:0] ISR_W  = ISR_OFS[AW-1:2];
  localparam logic [WW-1:0] IRR_W  = IRR_OFS[AW-1:2];

  logic [WW-1:0] w;
  logic          ctrl_wr;
  logic          unused_bits;

  assign w           = addr[AW-1:2];
  assign ctrl_wr     = wr && (w == CTRL_W);
  assign eoi_wr      = wr && (w == EOI_W);
  assign unused_bits = ^{addr[1:0], wdata[31:EN_BIT+1], wdata[EN_BIT-1:VW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      spur <= '1;
    end else if (ctrl_wr) begin
      en   <= wdata[EN_BIT];
      spur <= wdata[VW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (w == CTRL_W) begin
        rdata[VW-1:0] = spur;
        rdata[EN_BIT] = en;
      end
      for (int i = 0; i < NW; i++) begin
        if (w == ISR_W + WW'(i)) rdata = isr[i*32 +: 32];
        if (w == IRR_W + WW'(i)) rdata = irr[i*32 +: 32];
      end
    end
  end

  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en) && $stable(spur)); // R2

endmodule

// File: rtl/irq_acceptor.sv
module irq_acceptor #(
  parameter int NUM_VEC = 256,
  parameter int ADDR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       msg_valid,
  input  logic [$clog2(NUM_VEC)-1:0] msg_vector,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       irq_valid,
  output logic [$clog2(NUM_VEC)-1:0] irq_vector,
  input  logic                       irq_ack
);

  localparam int VW = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0] irr_q, isr_q;
  logic               en;
  logic [VW-1:0]      spur;
  logic               eoi_wr;
  logic               irr_any, isr_any;
  logic [VW-1:0]      irr_top, isr_top;
  logic               pend_q;

  // Named internal events
  logic msg_take, present_now, ack_take, ack_real, spur_take, eoi_real;

  assign msg_take    = msg_valid && en;
  assign present_now = en && irr_any && (!isr_any || (irr_top > isr_top));
  assign ack_take    = irq_ack && pend_q;
  assign ack_real    = ack_take && present_now;
  assign spur_take   = ack_take && !present_now;
  assign eoi_real    = eoi_wr && isr_any;

  irqa_regs #(.N(NUM_VEC), .VW(VW), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .irr(irr_q), .isr(isr_q),
    .en(en), .spur(spur), .eoi_wr(eoi_wr)
  );

  irqa_bitmap #(.N(NUM_VEC), .IW(VW)) u_irr (
    .clk(clk), .rst_n(rst_n),
    .set_en(msg_take), .set_idx(msg_vector),
    .clr_en(ack_real), .clr_idx(irr_top),
    .bits(irr_q)
  );

  irqa_bitmap #(.N(NUM_VEC), .IW(VW)) u_isr (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_real), .set_idx(irr_top),
    .clr_en(eoi_real), .clr_idx(isr_top),
    .bits(isr_q)
  );

  irqa_prio #(.N(NUM_VEC), .IW(VW)) u_irr_prio (
    .clk(clk), .rst_n(rst_n), .bits(irr_q), .any(irr_any), .top(irr_top)
  );

  irqa_prio #(.N(NUM_VEC), .IW(VW)) u_isr_prio (
    .clk(clk), .rst_n(rst_n), .bits(isr_q), .any(isr_any), .top(isr_top)
  );

  // Offer is registered; it drops for one cycle after every acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= present_now && !ack_take;
  end

  assign irq_valid  = pend_q;
  assign irq_vector = present_now ? irr_top : spur;

  AST_OFFER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(en)); // R3
  AST_MSG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_take |=> irr_q[$past(msg_vector)]); // R4
  AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_real |=> isr_any && !pend_q); // R6
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && isr_any && !ack_real |=> $countones(isr_q) + 1 == $past($countones(isr_q))); // R8
  AST_SPUR_NO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    spur_take && !eoi_wr && !msg_take |=> $stable(isr_q) && $stable(irr_q)); // R9

endmodule

// File: tb/sim_irq_acceptor.sv
module sim_irq_acceptor;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'hF0;
  localparam logic [7:0] A_EOI  = 8'hB0;

  // {expect valid, message vector, expected offered vector}
  localparam logic [16:0] TBL [6] = '{
    {1'b1, 8'h10, 8'h10},
    {1'b1, 8'h05, 8'h10},
    {1'b1, 8'h80, 8'h80},
    {1'b1, 8'h80, 8'h80},
    {1'b1, 8'hFF, 8'hFF},
    {1'b1, 8'h00, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [7:0]  msg_vector = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic        irq_ack = 1'b0;

  int checks = 0, errs = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_acceptor u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_ack(irq_ack)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v);
    msg_valid = 1'b1; msg_vector = v; step(); msg_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; step(); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a; #1; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  // Take the current offer, checking it names the expected vector.
  task automatic take(input string tag, input logic [7:0] exp);
    chk(tag, {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, exp});
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rdchk("R1 ctrl", A_CTRL, 32'h0000_00FF);
    chk("R1 valid", {31'b0, irq_valid}, 32'h0);
    rdchk("R1 isr", 8'h40, 32'h0);
    rdchk("R1 irr", 8'h7C, 32'h0);

    wr(A_CTRL, 32'h0000_01FF);
    rdchk("R2 ctrl", A_CTRL, 32'h0000_01FF);

    // R5 table walk: pending set accumulates, highest is offered
    for (int i = 0; i < 6; i++) begin
      send(TBL[i][15:8]);
      step();
      chk("R5 offer", {23'b0, irq_valid, irq_vector}, {23'b0, TBL[i][16], TBL[i][7:0]});
    end

    // R6 acknowledge moves 0xFF to service
    take("R6 vec", 8'hFF);
    rdchk("R6 isr", 8'h5C, 32'h8000_0000);
    rdchk("R6 irr", 8'h7C, 32'h0);
    step();
    chk("R7 lower held", {31'b0, irq_valid}, 32'h0);

    // R8 EOI retires 0xFF, 0x80 is then offered
    wr(A_EOI, 32'h0);
    step();
    rdchk("R8 isr clear", 8'h5C, 32'h0);
    chk("R8 next offer", {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, 8'h80});
    take("R6 vec80", 8'h80);
    rdchk("R4 merged", 8'h70, 32'h0);
    rdchk("R6 isr80", 8'h50, 32'h1);
    wr(A_EOI, 32'h0000_1234);
    rdchk("R8 any data", 8'h50, 32'h0);
    step();

    // R7 equal priority is held
    take("R5 vec10", 8'h10);
    send(8'h10);
    step();
    chk("R7 equal held", {31'b0, irq_valid}, 32'h0);
    rdchk("R4 irr word0", 8'h60, 32'h0001_0021);
    wr(A_EOI, 32'h0);
    step();
    chk("R7 after eoi", {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, 8'h10});
    take("R6 vec10b", 8'h10);
    wr(A_EOI, 32'h0);
    step();
    chk("R5 vec05", {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, 8'h05});

    // R9 disable under a standing offer, then acknowledge -> spurious
    wr(A_CTRL, 32'h0000_00E7);
    chk("R9 spurious vec", {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, 8'hE7});
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
    rdchk("R9 isr", 8'h40, 32'h0);
    rdchk("R9 irr", 8'h60, 32'h0000_0021);
    step();
    chk("R3 no offer", {31'b0, irq_valid}, 32'h0);

    // R3 disabled drops messages
    send(8'h70);
    step();
    rdchk("R3 dropped", 8'h6C, 32'h0);
    chk("R3 valid", {31'b0, irq_valid}, 32'h0);

    // R8 EOI with nothing in service
    wr(A_EOI, 32'h0);
    rdchk("R8 empty isr", 8'h40, 32'h0);
    rdchk("R8 empty irr", 8'h60, 32'h0000_0021);

    // Re-enable
    wr(A_CTRL, 32'h0000_01FF);
    step();
    chk("R5 reenable", {23'b0, irq_valid, irq_vector}, {23'b0, 1'b1, 8'h05});
    wr(A_CTRL, 32'hFFFF_FE80);
    rdchk("R2 upper zero", A_CTRL, 32'h0000_0080);

    // R10 unimplemented and write-only offsets
    rdchk("R10 off00", 8'h00, 32'h0);
    rdchk("R10 off80", 8'h80, 32'h0);
    rdchk("R10 eoi", A_EOI, 32'h0);
    rdchk("R10 offFC", 8'hFC, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule